// File: doc/BRIEF.md
# Burst Data-Timing Tracker

This block sits on the controller side of a low-latency DRAM interface that has separate read and write data pins. It watches every READ and WRITE command the controller issues and turns each one into per-cycle timing strobes. A launch strobe with a beat-pair index tells the write datapath when to drive each part of the burst. An expect strobe tells the read capture path in which cycles the device will return data. The block also drives the controller's termination enable for the read-data inputs.

The timing comes from a programmed read latency, a burst-length select and an address-multiplexing flag. Write latency is always one cycle more than read latency. Multiplexed addressing adds one further cycle to both. Data moves on both clock edges, so a burst of N beats fills N/2 clock cycles. Windows from back-to-back commands may overlap. If a new command's window shares a cycle with a pending window of the opposite direction, a one-cycle error flag is raised.

Top module: `burst_timing_tracker`

## Requirements
- R1: While reset is held and in the first cycle after it, `wr_launch`, `wr_beat`, `rd_expect` and `collide_err` are 0 and `term_en` is 1.
- R2: A read command sampled at clock edge k drives `rd_expect` high in the cycles that begin at edges k+L through k+L+S-1. Here L = max(rd_lat, 2) + addr_mux, and S is the burst span in cycles from R4. A `rd_lat` value of 0 or 1 behaves as 2.
- R3: A write command sampled at edge k drives `wr_launch` high in the cycles that begin at edges k+L+1 through k+L+S.
- R4: `burst_sel` gives the burst span: 0 is 2 beats (1 cycle), 1 is 4 beats (2 cycles), and 2 or 3 is 8 beats (4 cycles).
- R5: In each launch cycle, `wr_beat` gives the cycle's position in its burst, counting 0 to S-1. It is 0 when `wr_launch` is low. Where two write windows overlap, the launch strobe covers the union of both windows and the newer command sets the index.
- R6: With `addr_mux` set to 1, both the read window and the write window start one cycle later than with `addr_mux` set to 0.
- R7: `term_en` is low from the cycle before each read-expect cycle through the read-expect cycle itself, and high in all other cycles.
- R8: When a command's window shares a cycle with a pending window of the opposite direction, `collide_err` is high for exactly the one cycle that follows the edge that sampled the command. The command is still scheduled.
- R9: `rd_lat`, `burst_sel` and `addr_mux` are taken from the inputs only at edges where no read or write window is current or pending. At all other edges, the values captured last apply, and changes to the inputs have no effect on the strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is issued this cycle |
| cmd_write | input | 1 | 1 for a write command, 0 for a read command |
| rd_lat | input | RL_W | Programmed read latency in cycles |
| burst_sel | input | 2 | Burst length select (see R4) |
| addr_mux | input | 1 | Multiplexed-address mode, which adds one cycle of latency |
| wr_launch | output | 1 | Launch write burst data this cycle |
| wr_beat | output | 2 | Beat-pair index within the write burst |
| rd_expect | output | 1 | Read data from the device is due this cycle |
| term_en | output | 1 | Controller termination enable for the read-data inputs |
| collide_err | output | 1 | The last command overlapped a window of the opposite direction |

## Verification
Every strobe is registered. A command sampled at edge k therefore first shows up on the outputs in the cycle that begins at edge k+L for reads, and at edge k+L+1 for writes. `collide_err` appears in the cycle that begins at edge k itself. `term_en` falls one cycle before the first read-expect cycle. The bench drives inputs and samples outputs on falling edges. A behavioural model numbers the rising edges since reset and records the expected value of each output for each future cycle number. It compares all five outputs every cycle, so no check can depend on which process runs first at a rising edge. The stimulus covers back-to-back commands of the same direction, collisions between reads and writes, the latency floor, and configuration changes made while a window is in flight. It then ends with random traffic.

// File: rtl/btt_pkg.sv
package btt_pkg;
  localparam int MAX_SPAN = 4;
  localparam int BEAT_W   = 2;

  typedef enum logic [1:0] {
    BURST_2  = 2'd0,
    BURST_4  = 2'd1,
    BURST_8  = 2'd2,
    BURST_8B = 2'd3
  } burst_e;

  // clock cycles occupied by one burst (two beats per cycle)
  function automatic int unsigned span_cycles(input logic [1:0] sel);
    case (burst_e'(sel))
      BURST_2: return 1;
      BURST_4: return 2;
      default: return 4;
    endcase
  endfunction

  // first read-data cycle, counted from the command edge
  function automatic int unsigned read_start(input int unsigned rl,
                                             input logic mux,
                                             input int unsigned floor_rl);
    int unsigned base;
    base = (rl < floor_rl) ? floor_rl : rl;
    return base + (mux ? 1 : 0);
  endfunction

  // write data trails read data by one cycle
  function automatic int unsigned write_start(input int unsigned rl,
                                              input logic mux,
                                              input int unsigned floor_rl);
    return read_start(rl, mux, floor_rl) + 1;
  endfunction
endpackage

// File: rtl/btt_cfg_hold.sv
module btt_cfg_hold #(
  parameter int RL_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            busy,
  input  logic [RL_W-1:0] rl_in,
  input  logic [1:0]      bl_in,
  input  logic            mux_in,
  output logic [RL_W-1:0] rl_act,
  output logic [1:0]      bl_act,
  output logic            mux_act,
  output logic [RL_W-1:0] rl_held,
  output logic [1:0]      bl_held,
  output logic            mux_held
);
  // live inputs pass only while nothing is in flight
  always_comb begin
    rl_act  = busy ? rl_held  : rl_in;
    bl_act  = busy ? bl_held  : bl_in;
    mux_act = busy ? mux_held : mux_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rl_held  <= '0;
      bl_held  <= '0;
      mux_held <= 1'b0;
    end else begin
      rl_held  <= rl_act;
      bl_held  <= bl_act;
      mux_held <= mux_act;
    end
  end
endmodule

// File: rtl/btt_window_pipe.sv
module btt_window_pipe #(
  parameter int DEPTH  = 21,
  parameter int OFF_W  = 5,
  parameter int SPAN_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [OFF_W-1:0]  start,
  input  logic [SPAN_W-1:0] span,
  output logic [DEPTH-1:0]  mask_new,
  output logic [DEPTH-1:0]  ahead,
  output logic              cur,
  output logic              busy
);
  logic [DEPTH-1:0] slot_q;

  // bit d of the mask marks the cycle d edges after the command edge
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      mask_new[i] = (i >= int'(start)) && (i < int'(start) + int'(span));
    end
  end

  assign ahead = slot_q >> 1;
  assign cur   = slot_q[0];
  assign busy  = |slot_q;

  always_ff @(posedge clk) begin
    if (!rst_n) slot_q <= '0;
    else        slot_q <= ahead | (load ? mask_new : '0);
  end
endmodule

// File: rtl/btt_beat_tag.sv
module btt_beat_tag #(
  parameter int DEPTH  = 21,
  parameter int OFF_W  = 5,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [OFF_W-1:0]  start,
  input  logic [DEPTH-1:0]  mask,
  output logic [BEAT_W-1:0] beat_now
);
  logic [BEAT_W-1:0] tag_q [DEPTH];

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      logic [BEAT_W-1:0] fresh;
      logic [BEAT_W-1:0] shifted;
      assign fresh = BEAT_W'(g - int'(start));
      if (g == DEPTH - 1) begin : g_top
        assign shifted = '0;
      end else begin : g_mid
        assign shifted = tag_q[g+1];
      end
      always_ff @(posedge clk) begin
        if (!rst_n)                tag_q[g] <= '0;
        else if (load && mask[g])  tag_q[g] <= fresh;
        else                       tag_q[g] <= shifted;
      end
    end
  endgenerate

  assign beat_now = tag_q[0];
endmodule

// File: rtl/burst_timing_tracker.sv
module burst_timing_tracker
  import btt_pkg::*;
#(
  parameter int RL_W   = 4,
  parameter int MIN_RL = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [RL_W-1:0]   rd_lat,
  input  logic [1:0]        burst_sel,
  input  logic              addr_mux,
  output logic              wr_launch,
  output logic [BEAT_W-1:0] wr_beat,
  output logic              rd_expect,
  output logic              term_en,
  output logic              collide_err
);
  localparam int DEPTH  = (1 << RL_W) + MAX_SPAN + 1;
  localparam int OFF_W  = $clog2(DEPTH);
  localparam int SPAN_W = $clog2(MAX_SPAN + 1);

  logic              busy, rd_busy, wr_busy;
  logic [RL_W-1:0]   rl_act, rl_held;
  logic [1:0]        bl_act, bl_held;
  logic              mux_act, mux_held;
  logic [OFF_W-1:0]  rd_start, wr_start;
  logic [SPAN_W-1:0] span;
  logic [DEPTH-1:0]  rd_mask, wr_mask, rd_ahead, wr_ahead;
  logic              rd_cur, wr_cur;
  logic              rd_load, wr_load;
  logic              coll_hit, collide_q;

  assign busy = rd_busy | wr_busy;

  btt_cfg_hold #(.RL_W(RL_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .busy(busy),
    .rl_in(rd_lat), .bl_in(burst_sel), .mux_in(addr_mux),
    .rl_act(rl_act), .bl_act(bl_act), .mux_act(mux_act),
    .rl_held(rl_held), .bl_held(bl_held), .mux_held(mux_held)
  );

  assign rd_start = OFF_W'(read_start(int'(rl_act), mux_act, MIN_RL));
  assign wr_start = OFF_W'(write_start(int'(rl_act), mux_act, MIN_RL));
  assign span     = SPAN_W'(span_cycles(bl_act));
  assign rd_load  = cmd_valid && !cmd_write;
  assign wr_load  = cmd_valid &&  cmd_write;

  btt_window_pipe #(.DEPTH(DEPTH), .OFF_W(OFF_W), .SPAN_W(SPAN_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .load(rd_load), .start(rd_start), .span(span),
    .mask_new(rd_mask), .ahead(rd_ahead), .cur(rd_cur), .busy(rd_busy)
  );

  btt_window_pipe #(.DEPTH(DEPTH), .OFF_W(OFF_W), .SPAN_W(SPAN_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .load(wr_load), .start(wr_start), .span(span),
    .mask_new(wr_mask), .ahead(wr_ahead), .cur(wr_cur), .busy(wr_busy)
  );

  btt_beat_tag #(.DEPTH(DEPTH), .OFF_W(OFF_W), .BEAT_W(BEAT_W)) u_tag (
    .clk(clk), .rst_n(rst_n), .load(wr_load), .start(wr_start),
    .mask(wr_mask), .beat_now(wr_beat)
  );

  // new window against the opposite direction, both aligned to the coming edge
  assign coll_hit = (rd_load && |(rd_mask & wr_ahead)) ||
                    (wr_load && |(wr_mask & rd_ahead));

  always_ff @(posedge clk) begin
    if (!rst_n) collide_q <= 1'b0;
    else        collide_q <= coll_hit;
  end

  assign wr_launch   = wr_cur;
  assign rd_expect   = rd_cur;
  assign collide_err = collide_q;
  // off one cycle early so the device's first read beat lands unterminated
  assign term_en     = !(rd_cur || rd_ahead[0]);
endmodule

// File: rtl/btt_checker.sv
module btt_checker #(
  parameter int RL_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid,
  input logic            wr_launch,
  input logic [1:0]      wr_beat,
  input logic            rd_expect,
  input logic            term_en,
  input logic            collide_err,
  input logic            busy,
  input logic [RL_W-1:0] rl_held,
  input logic [1:0]      bl_held,
  input logic            mux_held
);
  p_term_off_in_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_expect |-> !term_en);

  p_beat_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_launch |-> (wr_beat == 2'd0));

  p_beat_has_prior_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_launch && wr_beat != 2'd0) |-> $past(wr_launch));

  p_collide_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    collide_err |-> $past(cmd_valid));

  p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(rl_held) && $stable(bl_held) && $stable(mux_held)));
endmodule

bind burst_timing_tracker btt_checker #(.RL_W(RL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid),
  .wr_launch(wr_launch), .wr_beat(wr_beat), .rd_expect(rd_expect),
  .term_en(term_en), .collide_err(collide_err), .busy(busy),
  .rl_held(rl_held), .bl_held(bl_held), .mux_held(mux_held)
);

// File: tb/sim_burst_timing_tracker.sv
module sim_burst_timing_tracker;
  localparam int NC = 4096;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_write = 1'b0;
  logic [3:0] rd_lat = 4'd0;
  logic [1:0] burst_sel = 2'd0;
  logic       addr_mux = 1'b0;
  logic       wr_launch, rd_expect, term_en, collide_err;
  logic [1:0] wr_beat;

  always #5 clk = ~clk;

  burst_timing_tracker u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .rd_lat(rd_lat), .burst_sel(burst_sel), .addr_mux(addr_mux),
    .wr_launch(wr_launch), .wr_beat(wr_beat), .rd_expect(rd_expect),
    .term_en(term_en), .collide_err(collide_err)
  );

  // expected outputs indexed by cycle number (cycle c begins at edge c)
  bit    e_rd  [NC];
  bit    e_wr  [NC];
  int    e_beat[NC];
  bit    e_col [NC];
  int    cyc = 0;
  int    last_end = -10;
  int    h_rl = 0, h_bl = 0, h_mux = 0;
  int    checks = 0, fails = 0;
  bit    done = 1'b0;
  string phase = "R2";

  function automatic int span_of(input int sel);
    if (sel == 0) return 1;
    if (sel == 1) return 2;
    return 4;
  endfunction

  // reference model: schedules each command's future cycles
  always @(posedge clk) begin
    int k, lat, s, c;
    bit hit;
    if (rst_n) begin
      cyc = cyc + 1;
      k = cyc;
      if (last_end < k - 1) begin   // R9: nothing in flight, take new settings
        h_rl  = int'(rd_lat);
        h_bl  = int'(burst_sel);
        h_mux = int'(addr_mux);
      end
      if (cmd_valid) begin
        lat = ((h_rl < 2) ? 2 : h_rl) + h_mux + (cmd_write ? 1 : 0);
        s   = span_of(h_bl);
        hit = 1'b0;
        for (int i = 0; i < s; i++) begin
          c = k + lat + i;
          if (cmd_write) begin
            if (e_rd[c]) hit = 1'b1;
            e_wr[c]   = 1'b1;
            e_beat[c] = i;
          end else begin
            if (e_wr[c]) hit = 1'b1;
            e_rd[c] = 1'b1;
          end
        end
        e_col[k] = hit;
        if (k + lat + s - 1 > last_end) last_end = k + lat + s - 1;
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s (phase %s) %s cycle %0d: actual %0d expected %0d",
               req, phase, what, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2", "rd_expect",   int'(rd_expect),   int'(e_rd[cyc]));
      chk("R3", "wr_launch",   int'(wr_launch),   int'(e_wr[cyc]));
      chk("R5", "wr_beat",     int'(wr_beat),     e_beat[cyc]);
      chk("R7", "term_en",     int'(term_en),     int'(!(e_rd[cyc] || e_rd[cyc+1])));
      chk("R8", "collide_err", int'(collide_err), int'(e_col[cyc]));
    end
  end

  task automatic issue(input bit w, input int rl, input int bl, input bit mx);
    cmd_valid = 1'b1;
    cmd_write = w;
    rd_lat    = 4'(rl);
    burst_sel = 2'(bl);
    addr_mux  = mx;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic gap(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL R1 watchdog: actual still running, expected finished");
      finish_run();
    end
  end

  initial begin
    gap(3);
    phase = "R1";
    // R1: outputs held at rest during reset
    chk("R1", "wr_launch reset",   int'(wr_launch),   0);
    chk("R1", "wr_beat reset",     int'(wr_beat),     0);
    chk("R1", "rd_expect reset",   int'(rd_expect),   0);
    chk("R1", "term_en reset",     int'(term_en),     1);
    chk("R1", "collide_err reset", int'(collide_err), 0);
    rst_n = 1'b1;
    gap(2);
    phase = "R2";   issue(0, 3, 0, 0); gap(10);
    phase = "R3";   issue(1, 3, 1, 0); gap(10);
    phase = "R4";   issue(0, 5, 2, 0); gap(12); issue(1, 4, 3, 0); gap(12);
    phase = "R6";   issue(0, 4, 1, 1); gap(10); issue(1, 4, 1, 1); gap(10);
    phase = "R2";   issue(0, 0, 0, 0); gap(6);  issue(0, 1, 1, 0); gap(6);
    phase = "R5";   issue(1, 4, 2, 0); issue(1, 4, 2, 0); issue(1, 4, 2, 0); gap(14);
    phase = "R8";   issue(0, 4, 2, 0); issue(1, 4, 2, 0); gap(14);
                    issue(1, 3, 1, 0); issue(0, 3, 1, 0); gap(12);
    phase = "R7";   issue(0, 2, 0, 0); gap(2); issue(0, 2, 0, 0); gap(8);
    phase = "R9";   issue(0, 6, 2, 0); issue(0, 2, 0, 1); gap(2);
                    issue(1, 9, 0, 0); gap(20); issue(0, 2, 0, 0); gap(8);
    phase = "R9";
    for (int n = 0; n < 500; n++) begin
      if (($urandom % 3) == 0) begin
        issue(1'($urandom % 2), int'($urandom % 16), int'($urandom % 4), 1'($urandom % 2));
      end else begin
        rd_lat    = 4'($urandom % 16);
        burst_sel = 2'($urandom % 4);
        addr_mux  = 1'($urandom % 2);
        @(negedge clk);
      end
    end
    gap(30);
    done = 1'b1;
    finish_run();
  end
endmodule